// File: doc/BRIEF.md
# Segmented Sliding-Window Marker Correlator

This block searches a stream of signed chip samples for a known, periodically repeated marker of N chips, each worth +1 or -1. On every accepted chip it delivers the correlation of the marker against the latest N samples. This makes it a sliding-window matched filter. It needs neither multipliers nor N parallel adders. The marker is cut into NUM_SEG segments of SEG_LEN chips each (N = NUM_SEG * SEG_LEN). One segment's short partial correlation is formed per clock cycle. The partial correlations are folded into a circular accumulator memory with one slot per pending window alignment. When the last segment has been folded into a slot, that slot holds the full sum and is emitted.

A controller with three states sequences the work. `ST_IDLE` is entered after reset and lasts until the first `start`. `ST_WAIT` waits for a chip strobe. `ST_SEG` walks the segment index from 0 to NUM_SEG-1, one per cycle. The transitions are as follows:
- `start` in any state goes to `ST_WAIT`.
- A strobe in `ST_WAIT` goes to `ST_SEG`.
- A strobe on the last segment step stays in `ST_SEG`, restarting at segment 0.
- The last step without a strobe returns to `ST_WAIT`.

A peak tracker groups the emitted values into periods of N. It reports the position in the period of the strongest match (largest magnitude), which a later synchronisation stage uses to align to the marker. The segment length is a compile-time parameter, so area can be traded against clock cycles per chip.

Top module: `seg_marker_corr`

## Requirements
- R1: After reset, `corr_valid`, `peak_valid` and `overrun` are 0 and stay 0 until chips are processed after `start`.
- R2: Chip strobes before the first `start` are ignored: they produce no `corr_valid` pulse and do not set `overrun`.
- R3: Chips are numbered t = 0, 1, ... from `start`. Chip t produces C(t) = sum over k = 0..N-1 of c_k * x(t-N+1+k). Here x is the signed sample, `marker[k]` = 1 means c_k = +1 and 0 means c_k = -1, and k = 0 pairs with the oldest sample. The value appears on `corr_value` with a one-cycle `corr_valid` pulse exactly NUM_SEG clock cycles after the edge that accepted chip t.
- R4: No value is emitted for chips t = 0 .. N-2 after a `start`. Every accepted chip from t = N-1 on emits exactly one value.
- R5: Strobes spaced exactly NUM_SEG cycles apart are all accepted, so a run of K chips at that rate yields K-N+1 values.
- R6: A strobe arriving fewer than NUM_SEG cycles after the last accepted strobe is dropped and is not counted as a chip. It sets `overrun`, which stays 1 until the next `start`.
- R7: Correlation values do not overflow. For N = 16, samples of +127 with an all-ones marker give +2032. Samples of -128 with an all-zeros marker give +2048. Samples of -128 with an all-ones marker give -2048.
- R8: Each N emitted values after `start` form one period. On the cycle the N-th value of a period is emitted, `peak_valid` pulses. `peak_mag` then shows the largest |C| of that period and `peak_index` the chip number t mod N where it occurred; on ties the earliest chip wins.
- R9: A `start` while a chip is being processed abandons that chip: it emits nothing, and the warm-up of R4 begins again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart: clears chip count, period and overrun |
| chip_stb | input | 1 | One-cycle strobe marking a new chip sample |
| chip_sample | input | SAMPLE_W | Signed chip sample |
| marker | input | N | Marker coefficients, bit k = 1 for +1, 0 for -1 |
| corr_valid | output | 1 | One-cycle pulse with each complete correlation |
| corr_value | output | ACC_W | Signed correlation value |
| peak_valid | output | 1 | One-cycle pulse at the end of each period |
| peak_index | output | log2(N) | Chip number mod N of the period's best match |
| peak_mag | output | ACC_W | Magnitude of the period's best match |
| overrun | output | 1 | Sticky flag: a strobe was dropped for arriving too soon |

## Verification
A correlation value is due exactly NUM_SEG edges after the edge that accepted its chip. The peak report is due on that same edge for the N-th value of a period. `overrun` is due one edge after a dropped strobe. The reference model in the bench records, for every accepted chip, the cycle number at which its value must appear. One nanosecond after each rising edge, the bench compares `corr_valid`, `corr_value`, the peak outputs and `overrun` against the model for that exact cycle. A value one cycle early or late is therefore caught both as a missing pulse and as an unexpected one.

// File: rtl/seg_corr_pkg.sv
package seg_corr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEG  = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/seg_corr_tap_sum.sv
// Holds the latest SEG_LEN samples and forms the partial correlation of
// one marker segment (selected by seg_sel) against them.
module seg_corr_tap_sum #(
    parameter  int SAMPLE_W = 8,
    parameter  int SEG_LEN  = 4,
    parameter  int NUM_SEG  = 4,
    parameter  int SEG_W    = 2,
    parameter  int PART_W   = 11,
    localparam int NCHIP    = SEG_LEN * NUM_SEG
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       shift_en,
    input  logic signed [SAMPLE_W-1:0] sample_in,
    input  logic [NCHIP-1:0]           marker,
    input  logic [SEG_W-1:0]           seg_sel,
    output logic signed [PART_W-1:0]   partial
);

    // Tap i holds the sample received i chips ago; it pairs with
    // coefficient (segment base + SEG_LEN-1-i).
    for (genvar i = 0; i < SEG_LEN; i++) begin : g_tap
        logic signed [SAMPLE_W-1:0] q;
        logic signed [PART_W-1:0]   ext;
        logic signed [PART_W-1:0]   term;
        logic signed [PART_W-1:0]   run;
        logic                       coef;

        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= '0;
                else if (clear)    q <= '0;
                else if (shift_en) q <= sample_in;
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        q <= '0;
                else if (clear)    q <= '0;
                else if (shift_en) q <= g_tap[i-1].q;
            end
        end

        always_comb begin
            coef = marker[int'(seg_sel) * SEG_LEN + (SEG_LEN - 1 - i)];
            ext  = PART_W'(q);
            term = coef ? ext : -ext;
        end

        if (i == 0) begin : g_sum0
            assign run = term;
        end else begin : g_sumn
            assign run = g_tap[i-1].run + term;
        end
    end

    assign partial = g_tap[SEG_LEN-1].run;

endmodule

// File: rtl/seg_corr_acc_mem.sv
// Circular accumulator store: one slot per pending window alignment.
module seg_corr_acc_mem #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 13
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic signed [DATA_W-1:0] wdata,
    output logic signed [DATA_W-1:0] rdata
);

    logic signed [DATA_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[addr] <= wdata;
    end

    assign rdata = slots[addr];

endmodule

// File: rtl/seg_corr_peak.sv
// Tracks the strongest match over each group of NCHIP emitted values.
module seg_corr_peak #(
    parameter int NCHIP = 16,
    parameter int IDX_W = 4,
    parameter int ACC_W = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    in_valid,
    input  logic signed [ACC_W-1:0] in_value,
    input  logic [IDX_W-1:0]        in_index,
    output logic                    peak_valid,
    output logic [IDX_W-1:0]        peak_index,
    output logic [ACC_W-1:0]        peak_mag
);

    localparam logic [IDX_W-1:0] CNT_LAST = IDX_W'(NCHIP - 1);

    logic [IDX_W-1:0] cnt_q;
    logic [ACC_W-1:0] best_mag_q;
    logic [IDX_W-1:0] best_idx_q;
    logic [ACC_W-1:0] cand_mag;
    logic [ACC_W-1:0] sel_mag;
    logic [IDX_W-1:0] sel_idx;

    always_comb begin
        cand_mag = in_value[ACC_W-1] ? ACC_W'(-in_value) : ACC_W'(in_value);
        if (cnt_q == '0 || cand_mag > best_mag_q) begin
            sel_mag = cand_mag;
            sel_idx = in_index;
        end else begin
            sel_mag = best_mag_q;
            sel_idx = best_idx_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            best_mag_q <= '0;
            best_idx_q <= '0;
            peak_valid <= 1'b0;
            peak_index <= '0;
            peak_mag   <= '0;
        end else if (clear) begin
            cnt_q      <= '0;
            best_mag_q <= '0;
            best_idx_q <= '0;
            peak_valid <= 1'b0;
        end else begin
            peak_valid <= 1'b0;
            if (in_valid) begin
                if (cnt_q == CNT_LAST) begin
                    peak_valid <= 1'b1;
                    peak_index <= sel_idx;
                    peak_mag   <= sel_mag;
                    cnt_q      <= '0;
                end else begin
                    best_mag_q <= sel_mag;
                    best_idx_q <= sel_idx;
                    cnt_q      <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/seg_marker_corr.sv
module seg_marker_corr
    import seg_corr_pkg::*;
#(
    parameter  int SAMPLE_W = 8,
    parameter  int SEG_LEN  = 4,
    parameter  int NUM_SEG  = 4,
    localparam int NCHIP    = SEG_LEN * NUM_SEG,
    localparam int IDX_W    = $clog2(NCHIP),
    localparam int SEG_W    = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int ACC_W    = SAMPLE_W + $clog2(NCHIP) + 1,
    localparam int PART_W   = SAMPLE_W + $clog2(SEG_LEN) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       chip_stb,
    input  logic signed [SAMPLE_W-1:0] chip_sample,
    input  logic [NCHIP-1:0]           marker,
    output logic                       corr_valid,
    output logic signed [ACC_W-1:0]    corr_value,
    output logic                       peak_valid,
    output logic [IDX_W-1:0]           peak_index,
    output logic [ACC_W-1:0]           peak_mag,
    output logic                       overrun
);

    localparam logic [SEG_W-1:0] SEG_LAST = SEG_W'(NUM_SEG - 1);
    localparam logic [IDX_W:0]   DEPTH_V  = (IDX_W+1)'(NCHIP);
    localparam logic [IDX_W-1:0] PTR_LAST = IDX_W'(NCHIP - 1);

    ctl_state_e state_q, state_d;

    logic [SEG_W-1:0]         seg_q;
    logic [IDX_W-1:0]         cur_ptr_q;
    logic [IDX_W-1:0]         next_ptr_q;
    logic [IDX_W:0]           chips_q;
    logic                     overrun_q;

    logic                     in_seg;
    logic                     last_step;
    logic                     accept;
    logic                     reject;
    logic                     emit;
    logic [IDX_W:0]           slot_sum;
    logic [IDX_W-1:0]         slot;
    logic signed [PART_W-1:0] partial;
    logic signed [ACC_W-1:0]  part_ext;
    logic signed [ACC_W-1:0]  slot_rd;
    logic signed [ACC_W-1:0]  slot_sum_val;
    logic signed [ACC_W-1:0]  slot_wr;
    logic                     slot_we;

    // Strobe acceptance: idle-waiting, or on the last segment step.
    always_comb begin
        in_seg    = (state_q == ST_SEG);
        last_step = in_seg && (seg_q == SEG_LAST);
        accept    = chip_stb && !start && ((state_q == ST_WAIT) || last_step);
        reject    = chip_stb && !start && in_seg && !last_step;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_WAIT: if (chip_stb) state_d = ST_SEG;
                ST_SEG:  if (last_step && !chip_stb) state_d = ST_WAIT;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Segment sequencing, chip pointers, warm-up count and overrun.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q      <= '0;
            cur_ptr_q  <= '0;
            next_ptr_q <= '0;
            chips_q    <= '0;
            overrun_q  <= 1'b0;
        end else if (start) begin
            seg_q      <= '0;
            cur_ptr_q  <= '0;
            next_ptr_q <= '0;
            chips_q    <= '0;
            overrun_q  <= 1'b0;
        end else begin
            if (accept) begin
                seg_q      <= '0;
                cur_ptr_q  <= next_ptr_q;
                next_ptr_q <= (next_ptr_q == PTR_LAST) ? '0 : next_ptr_q + 1'b1;
                if (chips_q != DEPTH_V) chips_q <= chips_q + 1'b1;
            end else if (last_step) begin
                seg_q <= '0;
            end else if (in_seg) begin
                seg_q <= seg_q + 1'b1;
            end
            if (reject) overrun_q <= 1'b1;
        end
    end

    // Slot of the window that segment seg_q's partial belongs to:
    // current chip plus (NUM_SEG-1-seg_q)*SEG_LEN, modulo NCHIP.
    always_comb begin
        slot_sum = {1'b0, cur_ptr_q}
                 + (IDX_W+1)'((NUM_SEG - 1 - int'(seg_q)) * SEG_LEN);
        if (slot_sum >= DEPTH_V) slot_sum = slot_sum - DEPTH_V;
        slot = slot_sum[IDX_W-1:0];
    end

    seg_corr_tap_sum #(
        .SAMPLE_W (SAMPLE_W),
        .SEG_LEN  (SEG_LEN),
        .NUM_SEG  (NUM_SEG),
        .SEG_W    (SEG_W),
        .PART_W   (PART_W)
    ) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .shift_en  (accept),
        .sample_in (chip_sample),
        .marker    (marker),
        .seg_sel   (seg_q),
        .partial   (partial)
    );

    // Segment 0 opens a slot by overwriting it; later segments add.
    always_comb begin
        part_ext     = ACC_W'(partial);
        slot_sum_val = slot_rd + part_ext;
        slot_wr      = (seg_q == '0) ? part_ext : slot_sum_val;
        slot_we      = in_seg && !start;
        emit         = last_step && !start && (chips_q == DEPTH_V);
    end

    seg_corr_acc_mem #(
        .DEPTH  (NCHIP),
        .ADDR_W (IDX_W),
        .DATA_W (ACC_W)
    ) u_acc (
        .clk   (clk),
        .we    (slot_we),
        .addr  (slot),
        .wdata (slot_wr),
        .rdata (slot_rd)
    );

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corr_valid <= 1'b0;
            corr_value <= '0;
        end else begin
            corr_valid <= emit;
            if (emit) corr_value <= slot_sum_val;
        end
    end

    seg_corr_peak #(
        .NCHIP (NCHIP),
        .IDX_W (IDX_W),
        .ACC_W (ACC_W)
    ) u_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (start),
        .in_valid   (emit),
        .in_value   (slot_sum_val),
        .in_index   (cur_ptr_q),
        .peak_valid (peak_valid),
        .peak_index (peak_index),
        .peak_mag   (peak_mag)
    );

    assign overrun = overrun_q;

endmodule

// File: rtl/seg_marker_corr_chk.sv
module seg_marker_corr_chk #(
    parameter int NCHIP    = 16,
    parameter int ACC_W    = 13,
    parameter int SAMPLE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    corr_valid,
    input logic signed [ACC_W-1:0] corr_value,
    input logic                    peak_valid,
    input logic [ACC_W-1:0]        peak_mag,
    input logic                    overrun
);

    localparam int LIMIT = NCHIP * (2 ** (SAMPLE_W - 1));

    logic started_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     started_q <= 1'b0;
        else if (start) started_q <= 1'b1;
    end

    // R2: nothing is reported before the first start.
    a_r2_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> (!corr_valid && !overrun));

    // R3: each result is a single-cycle pulse.
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |=> !corr_valid);

    // R6: overrun is sticky until start.
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !start) |=> overrun);

    // R6: start clears overrun.
    a_r6_overrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !overrun);

    // R7: values stay within the full-scale range.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        corr_valid |-> (int'(corr_value) <= LIMIT && int'(corr_value) >= -LIMIT));

    // R8: the peak report coincides with a correlation output.
    a_r8_peak_with_value: assert property (@(posedge clk) disable iff (!rst_n)
        peak_valid |-> corr_valid);

    // R8: reported magnitude is within range.
    a_r8_peak_bound: assert property (@(posedge clk) disable iff (!rst_n)
        peak_valid |-> (int'(peak_mag) <= LIMIT));

    // R9: a start suppresses the next output.
    a_r9_start_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !corr_valid);

endmodule

bind seg_marker_corr seg_marker_corr_chk #(
    .NCHIP    (NCHIP),
    .ACC_W    (ACC_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .corr_valid (corr_valid),
    .corr_value (corr_value),
    .peak_valid (peak_valid),
    .peak_mag   (peak_mag),
    .overrun    (overrun)
);

// File: tb/seg_marker_corr_tb.sv
`timescale 1ns/1ps
module seg_marker_corr_tb;

    localparam int L  = 4;
    localparam int M  = 4;
    localparam int N  = L * M;
    localparam int AW = 8 + $clog2(N) + 1;
    localparam int IW = $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic                 chip_stb = 1'b0;
    logic signed [7:0]    chip_sample = '0;
    logic [N-1:0]         marker = '0;
    logic                 corr_valid;
    logic signed [AW-1:0] corr_value;
    logic                 peak_valid;
    logic [IW-1:0]        peak_index;
    logic [AW-1:0]        peak_mag;
    logic                 overrun;

    seg_marker_corr #(.SAMPLE_W(8), .SEG_LEN(L), .NUM_SEG(M)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .chip_stb    (chip_stb),
        .chip_sample (chip_sample),
        .marker      (marker),
        .corr_valid  (corr_valid),
        .corr_value  (corr_value),
        .peak_valid  (peak_valid),
        .peak_index  (peak_index),
        .peak_mag    (peak_mag),
        .overrun     (overrun)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int q[$];
    int due_q[$];
    int val_q[$];
    int idx_q[$];
    bit started = 0;
    bit have_last = 0;
    int last_acc = 0;
    bit ovr_m = 0;
    int pcnt = 0;
    int pbest = 0;
    int pidx = 0;
    int valid_seen = 0;
    int last_corr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: update the model for the edge, then compare 1 ns later.
    task automatic tick();
        bit s_stb = chip_stb;
        bit s_st = start;
        int s_x = int'(chip_sample);
        bit exp_v;
        bit exp_pv;
        @(posedge clk);
        cyc++;
        if (rst_n) begin
            if (s_st) begin
                started = 1; have_last = 0; ovr_m = 0;
                q.delete(); due_q.delete(); val_q.delete(); idx_q.delete();
                pcnt = 0; pbest = 0; pidx = 0;
            end else if (s_stb && started) begin
                if (have_last && (cyc - last_acc) < M) begin
                    ovr_m = 1;
                end else begin
                    int t;
                    q.push_back(s_x);
                    have_last = 1;
                    last_acc = cyc;
                    t = q.size() - 1;
                    if (t >= N - 1) begin
                        int c = 0;
                        for (int k = 0; k < N; k++)
                            c += (marker[k] ? 1 : -1) * q[t - N + 1 + k];
                        due_q.push_back(cyc + M);
                        val_q.push_back(c);
                        idx_q.push_back(t % N);
                    end
                end
            end
        end
        #1;
        if (rst_n) begin
            exp_v  = (due_q.size() > 0) && (due_q[0] == cyc);
            exp_pv = 0;
            chk(corr_valid == exp_v, "R4", "corr_valid", int'(corr_valid), int'(exp_v));
            if (corr_valid) begin
                valid_seen++;
                last_corr = int'(corr_value);
            end
            if (exp_v) begin
                int ev = val_q.pop_front();
                int ei = idx_q.pop_front();
                int em = (ev < 0) ? -ev : ev;
                void'(due_q.pop_front());
                chk(int'(corr_value) == ev, "R3", "corr_value", int'(corr_value), ev);
                if (pcnt == 0 || em > pbest) begin
                    pbest = em;
                    pidx = ei;
                end
                if (pcnt == N - 1) begin
                    exp_pv = 1;
                    pcnt = 0;
                end else begin
                    pcnt++;
                end
            end
            while (due_q.size() > 0 && due_q[0] < cyc) begin
                void'(due_q.pop_front());
                void'(val_q.pop_front());
                void'(idx_q.pop_front());
            end
            chk(peak_valid == exp_pv, "R8", "peak_valid", int'(peak_valid), int'(exp_pv));
            if (exp_pv && peak_valid) begin
                chk(int'(peak_index) == pidx, "R8", "peak_index", int'(peak_index), pidx);
                chk(int'(peak_mag) == pbest, "R8", "peak_mag", int'(peak_mag), pbest);
            end
            chk(overrun == ovr_m, "R6", "overrun", int'(overrun), int'(ovr_m));
        end
    endtask

    task automatic send(input int x, input int gap);
        chip_sample = 8'(x);
        chip_stb = 1'b1;
        tick();
        chip_stb = 1'b0;
        repeat (gap - 1) tick();
    endtask

    task automatic do_start();
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        chk(corr_valid == 0, "R1", "corr_valid", int'(corr_valid), 0);
        chk(peak_valid == 0, "R1", "peak_valid", int'(peak_valid), 0);
        chk(overrun == 0, "R1", "overrun", int'(overrun), 0);

        // R2: strobes before start
        marker = 16'hB38E;
        for (int i = 0; i < 6; i++) send(int'($urandom % 256) - 128, 2);
        repeat (8) tick();
        chk(valid_seen == 0, "R2", "outputs before start", valid_seen, 0);
        chk(overrun == 0, "R2", "overrun before start", int'(overrun), 0);

        // R5: full-rate stream of random samples
        do_start();
        v0 = valid_seen;
        for (int i = 0; i < 40; i++) send(int'($urandom % 256) - 128, M);
        repeat (8) tick();
        chk(valid_seen - v0 == 40 - N + 1, "R5", "values at full rate", valid_seen - v0, 40 - N + 1);

        // R3: slower spacing
        for (int i = 0; i < 20; i++) send(int'($urandom % 256) - 128, M + 3);
        repeat (8) tick();

        // R8: embedded marker with noise, offset alignment
        do_start();
        for (int i = 0; i < 56; i++)
            send((marker[(i + 5) % N] ? 90 : -90) + int'($urandom % 9) - 4, M);
        repeat (8) tick();

        // R6: too-early strobe is dropped, overrun sticks until start
        send(10, 2);
        send(20, M);
        for (int i = 0; i < 5; i++) send(i * 7, M);
        repeat (4) tick();
        chk(overrun == 1, "R6", "overrun after early strobe", int'(overrun), 1);
        do_start();
        tick();
        chk(overrun == 0, "R6", "overrun after start", int'(overrun), 0);

        // R7: full-scale values
        marker = '1;
        do_start();
        for (int i = 0; i < 20; i++) send(127, M);
        repeat (6) tick();
        chk(last_corr == 2032, "R7", "max positive samples", last_corr, 2032);
        marker = '0;
        do_start();
        for (int i = 0; i < 20; i++) send(-128, M);
        repeat (6) tick();
        chk(last_corr == 2048, "R7", "max magnitude positive", last_corr, 2048);
        marker = '1;
        do_start();
        for (int i = 0; i < 20; i++) send(-128, M);
        repeat (6) tick();
        chk(last_corr == -2048, "R7", "max magnitude negative", last_corr, -2048);

        // R9: start while a chip is in flight
        marker = 16'h5A3C;
        do_start();
        for (int i = 0; i < 20; i++) send(int'($urandom % 256) - 128, M);
        chip_sample = 8'sd33;
        chip_stb = 1'b1;
        tick();
        chip_stb = 1'b0;
        do_start();
        v0 = valid_seen;
        for (int i = 0; i < N; i++) send(int'($urandom % 256) - 128, M);
        repeat (8) tick();
        chk(valid_seen - v0 == 1, "R9", "values after restart", valid_seen - v0, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule